// File: doc/BRIEF.md
# AXI4 Burst Address and Strobe Generator

This block turns one AXI4 address-channel request into the sequence of beat addresses and write-strobe masks that the data channel needs. A request carries a start address, a length field (beats minus one), a size code (log2 of the bytes per beat) and a burst type. The block accepts it on a valid/ready handshake, checks that it is legal, and then offers one beat at a time on a second valid/ready stream. Each beat carries its address, the byte-lane mask for a data bus of `DATA_W` bits, and a last-beat flag.

Both streams obey the usual back-pressure rules. `req_ready` is high only while no burst is in progress, so a new request waits until the last beat of the previous one has been accepted. A beat is offered with `beat_valid` and stays unchanged until `beat_ready` takes it. The sequence moves on only when a beat is transferred. An illegal request is still accepted, but it produces no beats. Instead `req_err` pulses for one cycle.

Burst type encoding: 0 = FIXED, 1 = INCR, 2 = WRAP, 3 = reserved.

Top module: `axi_burst_agen`

## Requirements
- R1: After reset, `req_ready` is 1, `beat_valid` is 0 and `req_err` is 0.
- R2: In a FIXED burst (code 0), every beat carries the request's start address unchanged.
- R3: In an INCR burst (code 1), beat 0 carries the start address. Beat i>0 carries the start address rounded down to a multiple of 2^size, plus i·2^size.
- R4: A WRAP burst (code 2) runs over a window of 2^size·(len+1) bytes whose base is the start address rounded down to that span. Beat i carries base + ((start − base + i·2^size) mod span).
- R5: The strobe of a beat sets lane j (bit j, lane = byte offset within the bus word) exactly when j ≥ (address mod bus bytes) and j lies inside the same 2^size-aligned lane group as that offset. Aligned beats therefore set 2^size lanes, and unaligned beats set only the upper part of the group.
- R6: `beat_last` is 1 exactly on beat index len, so a burst has len+1 beats (1 to 256 with an 8-bit field). After the last beat is accepted, `beat_valid` falls and `req_ready` rises on the next cycle.
- R7: A request is illegal if it has burst code 3, a size code above log2(bus bytes), or a WRAP burst with len not in {1, 3, 7, 15} or a start not aligned to 2^size. For an illegal request, `req_err` is 1 in the cycle after acceptance and no beat is offered.
- R8: An INCR request whose aligned start offset within its 4 KB page, plus 2^size·(len+1), exceeds 4096 is illegal and handled as in R7. FIXED bursts are not subject to this check.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, the beat address, strobe and last flag hold steady. `req_ready` is 0 whenever `beat_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | 0 FIXED, 1 INCR, 2 WRAP, 3 reserved |
| req_err | output | 1 | One-cycle pulse: accepted request was illegal |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_strb | output | DATA_W/8 | Byte-lane write strobe of the current beat |
| beat_last | output | 1 | Current beat is the final one |

## Verification
The bench sweeps every burst code and every size code on a 32-bit bus. It uses lengths 1, 2, 3, 4, 8, 16 and 256 beats and start addresses both aligned and offset by one to three bytes. Comparing FIXED and INCR on unaligned starts shows whether realignment after the first beat and the partial first strobe are right. WRAP starts in the middle of a window show whether the wrap point and base are right. Starts just below a 4 KB boundary separate INCR bursts that fit in the page from those that cross it. Stalls of `beat_ready` at varying beat positions confirm that beats hold steady and that the sequence advances only on a transfer.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2,
    BT_RSVD  = 2'd3
  } burst_e;
endpackage

// File: rtl/agen_check.sv
module agen_check
  import agen_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 8,
  parameter int STRB_W   = 4,
  parameter int BND_BITS = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  output logic              bad,
  output logic [ADDR_W-1:0] wrap_lo,
  output logic [ADDR_W-1:0] wrap_mask
);
  localparam int MAX_SZ = $clog2(STRB_W);
  localparam int CW     = BND_BITS + LEN_W + MAX_SZ + 8;

  logic [ADDR_W-1:0] sz_mask;
  logic [CW-1:0]     span;
  logic [CW-1:0]     page_start;
  logic              size_ok, wrap_len_ok, crosses;

  always_comb begin
    size_ok     = size <= 3'(MAX_SZ);
    sz_mask     = (ADDR_W'(1) << size) - ADDR_W'(1);
    span        = (CW'(len) + CW'(1)) << size;
    wrap_mask   = ADDR_W'(span) - ADDR_W'(1);
    wrap_lo     = addr & ~wrap_mask;
    wrap_len_ok = (len == LEN_W'(1)) || (len == LEN_W'(3)) ||
                  (len == LEN_W'(7)) || (len == LEN_W'(15));
    page_start  = CW'(addr[BND_BITS-1:0] & ~sz_mask[BND_BITS-1:0]);
    crosses     = (page_start + span) > (CW'(1) << BND_BITS);
    case (burst_e'(burst))
      BT_FIXED: bad = 1'b0;
      BT_INCR:  bad = crosses;
      BT_WRAP:  bad = !wrap_len_ok || ((addr & sz_mask) != '0);
      default:  bad = 1'b1;
    endcase
    if (!size_ok) bad = 1'b1;
  end
endmodule

// File: rtl/agen_step.sv
module agen_step
  import agen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [2:0]        size,
  input  logic [1:0]        burst,
  input  logic [ADDR_W-1:0] wrap_lo,
  input  logic [ADDR_W-1:0] wrap_mask,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] step, aligned_up;

  always_comb begin
    step       = ADDR_W'(1) << size;
    aligned_up = (cur & ~(step - ADDR_W'(1))) + step;
    case (burst_e'(burst))
      BT_INCR: nxt = aligned_up;
      BT_WRAP: nxt = wrap_lo | (aligned_up & wrap_mask);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/agen_strobe.sv
module agen_strobe #(
  parameter int STRB_W = 4
) (
  input  logic [$clog2(STRB_W)-1:0] lane,
  input  logic [2:0]                size,
  output logic [STRB_W-1:0]         strb
);
  localparam int LANE_W = $clog2(STRB_W);

  logic [LANE_W-1:0] grp_mask;
  assign grp_mask = (LANE_W'(1) << size) - LANE_W'(1);

  for (genvar j = 0; j < STRB_W; j++) begin : g_lane
    assign strb[j] = (LANE_W'(j) >= lane) &&
                     ((LANE_W'(j) & ~grp_mask) == (lane & ~grp_mask));
  end
endmodule

// File: rtl/axi_burst_agen.sv
module axi_burst_agen #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int BND_BITS = 12,
  localparam int STRB_W  = DATA_W / 8,
  localparam int LANE_W  = $clog2(STRB_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  output logic              req_err,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [STRB_W-1:0] beat_strb,
  output logic              beat_last
);
  logic              busy_q, err_q;
  logic [LEN_W-1:0]  cnt_q, len_q;
  logic [2:0]        size_q;
  logic [1:0]        burst_q;
  logic [ADDR_W-1:0] cur_q, wlo_q, wmask_q;

  logic              chk_bad;
  logic [ADDR_W-1:0] chk_wlo, chk_wmask, nxt_addr;
  logic              take_req, take_beat;

  agen_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRB_W(STRB_W), .BND_BITS(BND_BITS)
  ) u_check (
    .addr(req_addr), .len(req_len), .size(req_size), .burst(req_burst),
    .bad(chk_bad), .wrap_lo(chk_wlo), .wrap_mask(chk_wmask)
  );

  agen_step #(.ADDR_W(ADDR_W)) u_step (
    .cur(cur_q), .size(size_q), .burst(burst_q),
    .wrap_lo(wlo_q), .wrap_mask(wmask_q), .nxt(nxt_addr)
  );

  agen_strobe #(.STRB_W(STRB_W)) u_strobe (
    .lane(cur_q[LANE_W-1:0]), .size(size_q), .strb(beat_strb)
  );

  assign req_ready  = !busy_q;
  assign req_err    = err_q;
  assign beat_valid = busy_q;
  assign beat_addr  = cur_q;
  assign beat_last  = busy_q && (cnt_q == len_q);
  assign take_req   = req_valid && req_ready;
  assign take_beat  = beat_valid && beat_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      size_q  <= '0;
      burst_q <= '0;
      cur_q   <= '0;
      wlo_q   <= '0;
      wmask_q <= '0;
    end else begin
      err_q <= take_req && chk_bad;
      if (take_req && !chk_bad) begin
        busy_q  <= 1'b1;
        cnt_q   <= '0;
        len_q   <= req_len;
        size_q  <= req_size;
        burst_q <= req_burst;
        cur_q   <= req_addr;
        wlo_q   <= chk_wlo;
        wmask_q <= chk_wmask;
      end else if (take_beat) begin
        if (beat_last) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
          cur_q <= nxt_addr;
        end
      end
    end
  end
endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_burst,
  input logic              req_err,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [STRB_W-1:0] beat_strb,
  input logic              beat_last
);
  localparam int LANE_W = $clog2(STRB_W);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
                                  $stable(beat_strb) && $stable(beat_last));

  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  // R5
  strb_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_strb[beat_addr[LANE_W-1:0]]);

  // R5
  strb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && (beat_addr[LANE_W-1:0] == '0) |-> beat_strb[0]);

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_burst == 2'd3) |=> req_err && !beat_valid);

  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> !beat_valid && req_ready);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !beat_valid);
endmodule

bind axi_burst_agen agen_chk #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_burst(req_burst), .req_err(req_err), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_strb(beat_strb),
  .beat_last(beat_last)
);

// File: tb/sim_axi_burst_agen.sv
module sim_axi_burst_agen;
  localparam int AW = 32;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_len = '0;
  logic [2:0]    req_size = '0;
  logic [1:0]    req_burst = '0;
  logic          req_err;
  logic          beat_valid;
  logic          beat_ready = 1'b1;
  logic [AW-1:0] beat_addr;
  logic [SW-1:0] beat_strb;
  logic          beat_last;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  axi_burst_agen u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
    .req_burst(req_burst), .req_err(req_err), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_strb(beat_strb),
    .beat_last(beat_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_bad(input longint a, input int len, input int sz, input int bt);
    longint bytes = longint'(1) << sz;
    longint as_pg = (a % 4096) & ~(bytes - 1);
    if (bt == 3 || sz > 2) return 1'b1;
    if (bt == 2) return !(len == 1 || len == 3 || len == 7 || len == 15) || (a % bytes != 0);
    if (bt == 1) return (as_pg + bytes * (len + 1)) > 4096;
    return 1'b0;
  endfunction

  function automatic longint exp_addr(input longint a, input int len, input int sz,
                                      input int bt, input int i);
    longint bytes = longint'(1) << sz;
    longint span  = bytes * (len + 1);
    longint lo    = a & ~(span - 1);
    if (bt == 0) return a;
    if (bt == 1) return (i == 0) ? a : (a & ~(bytes - 1)) + i * bytes;
    return lo + ((a - lo + i * bytes) % span);
  endfunction

  function automatic logic [SW-1:0] exp_strb(input longint a, input int sz);
    int lane  = int'(a % SW);
    int bytes = 1 << sz;
    int al    = lane & ~(bytes - 1);
    logic [SW-1:0] m = '0;
    for (int j = 0; j < SW; j++) m[j] = (j >= lane) && (j < al + bytes);
    return m;
  endfunction

  task automatic run_burst(input longint a, input int len, input int sz, input int bt,
                           input int seed);
    bit    e = exp_bad(a, len, sz, bt);
    string areq = (bt == 0) ? "R2" : (bt == 1) ? "R3" : "R4";
    string ereq = (bt == 1 && sz <= 2) ? "R8" : "R7";
    @(negedge clk);
    check(req_ready == 1'b1, "R9 idle ready", longint'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    req_len   = 8'(len);
    req_size  = 3'(sz);
    req_burst = 2'(bt);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(req_err == e, ereq, longint'(req_err), longint'(e));
    check(beat_valid == !e, ereq, longint'(beat_valid), longint'(!e));
    if (!e) begin
      for (int i = 0; i <= len; i++) begin
        longint ea = exp_addr(a, len, sz, bt, i);
        logic [SW-1:0] es = exp_strb(ea, sz);
        if ((i + seed) % 5 == 2) begin
          beat_ready = 1'b0;
          @(posedge clk);
          #1;
          check(beat_valid && beat_addr == AW'(ea), "R9 stall hold", longint'(beat_addr), ea);
          beat_ready = 1'b1;
        end
        check(beat_addr == AW'(ea), areq, longint'(beat_addr), ea);
        check(beat_strb == es, "R5", longint'(beat_strb), longint'(es));
        check(beat_last == (i == len), "R6", longint'(beat_last), longint'(i == len));
        @(posedge clk);
        #1;
      end
      check(!beat_valid && req_ready, "R6 end", longint'({beat_valid, req_ready}), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    automatic int lens[7] = '{0, 1, 2, 3, 7, 15, 255};
    automatic longint addrs[10] = '{'h1000, 'h1001, 'h1002, 'h1003, 'h1008,
                                    'h100C, 'h1FF0, 'h1FF6, 'h1FFC, 'h1FFE};
    automatic int seed = 0;
    repeat (3) @(posedge clk);
    #1;
    check(req_ready == 1'b1 && beat_valid == 1'b0 && req_err == 1'b0, "R1 reset",
          longint'({req_ready, beat_valid, req_err}), 'b100);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(req_ready == 1'b1 && beat_valid == 1'b0, "R1 after reset",
          longint'({req_ready, beat_valid}), 'b10);
    for (int bt = 0; bt < 4; bt++)
      for (int sz = 0; sz < 4; sz++)
        foreach (lens[li])
          foreach (addrs[ai]) begin
            run_burst(addrs[ai], lens[li], sz, bt, seed);
            seed++;
          end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule